// File: doc/BRIEF.md
# Debug-Port Memory Access Engine

This block lives on the target side of a debug port. Three registers (address, data and control) are written and read back by the debug shift logic. When the probe sets the start flag with the access-enable bit set, the engine runs exactly one transfer of the chosen width on a simple request/ready/error system bus. It then drops the start flag, which the probe polls as a busy bit.

The engine records a failed transfer in a sticky error flag. On a read, it places the returned lanes into the data register. Write data is taken as already copied across all byte lanes, and the engine derives the byte enables from the size and the low address bits. A size the bus cannot express, or a halfword at an odd address, is refused and no bus cycle is issued.

Top module: `dbg_dma_engine`

## Requirements
- R1: After a synchronous reset, the address, data and control read-back are all zero and bus_req is low.
- R2: Register select codes are 0 address, 1 data and 2 control; code 3 writes nothing. In the control word, the access enable is bit 17, start is bit 11, error is bit 10 and read-not-write is bit 9. The size field sits in bits [8:7], coded 00 byte, 01 halfword, 10 word and 11 triple-byte. All other control bits read 0, and writing a 1 to the error bit never sets it.
- R3: A transfer is launched only by a control write, made while idle, that carries both start=1 and enable=1. A start written with enable=0 produces no bus request and leaves start at 0.
- R4: bus_req rises in the cycle after the launching write and holds until the cycle in which bus_ready is seen. bus_addr, bus_we and bus_be stay stable throughout. Start reads 1 from the launching edge until the ready edge, and each transfer produces exactly one handshake.
- R5: bus_be is 0001 shifted left by address[1:0] for a byte, 0011 or 1100 (chosen by address bit 1) for a halfword, and 1111 for a word. bus_addr is the address register, bus_wdata is the data register unchanged, and bus_we is the inverse of read-not-write.
- R6: A read that completes without error loads the data register with bus_rdata, with every lane outside bus_be forced to zero.
- R7: bus_err at the ready cycle sets the error flag, and an erroring read leaves the data register unchanged.
- R8: A launch with triple-byte size, or with halfword size and address bit 0 set, sets the error flag at the launching edge. It issues no bus request and leaves start at 0.
- R9: The error flag stays set across later transfers. Only a control write made while idle with enable=0 and error bit=0 clears it.
- R10: While start is 1, writes to every register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe from the debug shift logic |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | 32 | Value to write |
| addr_rd | output | 32 | Address register read-back |
| data_rd | output | 32 | Data register read-back |
| ctrl_rd | output | 32 | Control register read-back |
| bus_req | output | 1 | Bus request, held until ready |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte-lane enables |
| bus_ready | input | 1 | Bus completion |
| bus_err | input | 1 | Bus error, valid with ready |
| bus_rdata | input | 32 | Bus read data, valid with ready |

## Verification
A launching control write shows its effect one clock later. At the next falling edge after that write, the bench checks bus_req, start and the bus fields, or the error flag for a refused size. Completion lands on the edge that samples bus_ready. The bench therefore polls the start bit at falling edges and checks the error flag, the data register and the handshake count as soon as start reads 0. Writes made during a transfer are checked only after that transfer completes, at the same registers they tried to change.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam int CTL_EN    = 17;
    localparam int CTL_START = 11;
    localparam int CTL_ERR   = 10;
    localparam int CTL_RNW   = 9;
    localparam int CTL_SZ_LO = 7;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_TRIPLE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       en;
        logic       rnw;
        xfer_size_e size;
    } xfer_cfg_t;

    function automatic logic [LANES-1:0] lane_enables(xfer_size_e sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: lane_enables = 4'b0001 << lo;
            SZ_HALF: lane_enables = lo[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: lane_enables = 4'b1111;
            default: lane_enables = 4'b0000;
        endcase
    endfunction

    function automatic logic size_refused(xfer_size_e sz, logic [1:0] lo);
        size_refused = (sz == SZ_TRIPLE) || (sz == SZ_HALF && lo[0]);
    endfunction
endpackage

// File: rtl/dma_lane_unit.sv
module dma_lane_unit
    import dma_pkg::*;
(
    input  xfer_size_e          size,
    input  logic [1:0]          addr_lo,
    input  logic [DATA_W-1:0]   rdata,
    output logic [LANES-1:0]    be,
    output logic [DATA_W-1:0]   rd_merged
);
    assign be = lane_enables(size, addr_lo);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_merged[8*i +: 8] = be[i] ? rdata[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic bus_ready,
    output logic req,
    output logic done
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else if (launch)
            req_q <= 1'b1;
        else if (req_q && bus_ready)
            req_q <= 1'b0;
    end

    assign req  = req_q;
    assign done = req_q && bus_ready;
endmodule

// File: rtl/dma_reg_file.sv
module dma_reg_file
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done,
    input  logic              done_err,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output xfer_cfg_t         cfg_q,
    output logic              start_q,
    output logic              err_q,
    output logic              launch
);
    xfer_cfg_t  cfg_new;
    logic       ctrl_wr;
    logic       try_go;
    logic       refuse;
    logic       clr_err;

    assign cfg_new.en   = wr_data[CTL_EN];
    assign cfg_new.rnw  = wr_data[CTL_RNW];
    assign cfg_new.size = xfer_size_e'(wr_data[CTL_SZ_LO +: 2]);

    assign ctrl_wr = wr_en && !start_q && (wr_sel == SEL_CTRL);
    assign try_go  = ctrl_wr && wr_data[CTL_EN] && wr_data[CTL_START];
    assign refuse  = try_go && size_refused(cfg_new.size, addr_q[1:0]);
    assign launch  = try_go && !refuse;
    assign clr_err = ctrl_wr && !wr_data[CTL_EN] && !wr_data[CTL_ERR];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            data_q  <= '0;
            cfg_q   <= '0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (done) begin
            start_q <= 1'b0;
            if (done_err)
                err_q <= 1'b1;
            else if (cfg_q.rnw)
                data_q <= rd_word;
        end else if (wr_en && !start_q) begin
            case (wr_sel)
                SEL_ADDR: addr_q <= wr_data[ADDR_W-1:0];
                SEL_DATA: data_q <= wr_data;
                SEL_CTRL: begin
                    cfg_q <= cfg_new;
                    if (launch)
                        start_q <= 1'b1;
                    if (refuse)
                        err_q <= 1'b1;
                    else if (clr_err)
                        err_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dbg_dma_engine.sv
module dbg_dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] addr_rd,
    output logic [DATA_W-1:0] data_rd,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LANES-1:0]  bus_be,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    xfer_cfg_t         cfg_q;
    logic              start_q;
    logic              err_q;
    logic              launch;
    logic              req;
    logic              done;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] rd_merged;

    dma_reg_file #(.ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_sel_e'(reg_sel)),
        .wr_data  (reg_wdata),
        .done     (done),
        .done_err (bus_err),
        .rd_word  (rd_merged),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .cfg_q    (cfg_q),
        .start_q  (start_q),
        .err_q    (err_q),
        .launch   (launch)
    );

    dma_bus_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .bus_ready (bus_ready),
        .req       (req),
        .done      (done)
    );

    dma_lane_unit i_lanes (
        .size      (cfg_q.size),
        .addr_lo   (addr_q[1:0]),
        .rdata     (bus_rdata),
        .be        (be),
        .rd_merged (rd_merged)
    );

    always_comb begin
        ctrl_rd                    = '0;
        ctrl_rd[CTL_EN]            = cfg_q.en;
        ctrl_rd[CTL_START]         = start_q;
        ctrl_rd[CTL_ERR]           = err_q;
        ctrl_rd[CTL_RNW]           = cfg_q.rnw;
        ctrl_rd[CTL_SZ_LO +: 2]    = cfg_q.size;
    end

    assign addr_rd   = addr_q;
    assign data_rd   = data_q;
    assign bus_req   = req;
    assign bus_we    = req && !cfg_q.rnw;
    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;
    assign bus_be    = req ? be : '0;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] addr_rd,
    input logic [31:0] ctrl_rd,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [3:0]  bus_be,
    input logic        bus_ready
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_be));

    p_start_clears_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ready |=> !ctrl_rd[11] && !bus_req);

    p_req_needs_start_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ctrl_rd[11] && ctrl_rd[17]);

    p_lane_count_r5: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4));

    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_sel == 2'd2 && !ctrl_rd[11] && reg_wdata[17] && reg_wdata[11]
        && reg_wdata[8:7] == 2'b11 |=> ctrl_rd[10] && !bus_req && !ctrl_rd[11]);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[10] && !(reg_wr_en && reg_sel == 2'd2) |=> ctrl_rd[10]);

    p_busy_addr_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[11] |=> $stable(addr_rd));
endmodule

bind dbg_dma_engine dma_engine_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .addr_rd   (addr_rd),
    .ctrl_rd   (ctrl_rd),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_ready (bus_ready)
);

// File: tb/test_dbg_dma_engine.sv
module test_dbg_dma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] addr_rd, data_rd, ctrl_rd;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ready = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int hs_count = 0;
    int wait_cnt = 0;
    int resp_delay = 0;
    logic resp_err = 1'b0;
    logic [31:0] exp_data = '0;
    logic        exp_err  = 1'b0;

    always #2 clk = ~clk;

    dbg_dma_engine i_dbg_dma_engine (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .addr_rd(addr_rd), .data_rd(data_rd), .ctrl_rd(ctrl_rd),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1357};
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] lo);
        if (sz == 2'b00) return 4'b0001 << lo;
        if (sz == 2'b01) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic refused(logic [1:0] sz, logic [1:0] lo);
        return sz == 2'b11 || (sz == 2'b01 && lo[0]);
    endfunction

    task automatic report;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bus responder, acts on falling edges
    always @(negedge clk) begin
        if (bus_ready) begin
            bus_ready = 1'b0;
            bus_err   = 1'b0;
        end else if (bus_req) begin
            if (wait_cnt >= resp_delay) begin
                bus_ready = 1'b1;
                bus_err   = resp_err;
                bus_rdata = mem_word(bus_addr);
                hs_count++;
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic reg_write(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(logic en, logic go, logic rnw, logic [1:0] sz);
        logic [31:0] w = '0;
        w[17] = en; w[11] = go; w[9] = rnw; w[8:7] = sz;
        return w;
    endfunction

    task automatic xfer(logic [31:0] a, logic [31:0] d, logic rnw, logic [1:0] sz,
                        int dly, logic berr);
        int hs0;
        resp_delay = dly;
        resp_err   = berr;
        reg_write(2'd0, a);
        if (!rnw) begin
            reg_write(2'd1, d);
            exp_data = d;
        end
        hs0 = hs_count;
        reg_write(2'd2, ctrl_word(1'b1, 1'b1, rnw, sz));
        if (refused(sz, a[1:0])) begin
            exp_err = 1'b1;
            chk(bus_req, 0, "R8 no request");
            chk(ctrl_rd[11], 0, "R8 start stays 0");
            chk(ctrl_rd[10], 1, "R8 error set");
            repeat (3) @(negedge clk);
            chk(hs_count, hs0, "R8 no handshake");
        end else begin
            chk(bus_req, 1, "R4 request after launch");
            chk(ctrl_rd[11], 1, "R4 start set");
            chk(bus_be, exp_be(sz, a[1:0]), "R5 byte enables");
            chk(bus_addr, a, "R5 address");
            chk(bus_we, !rnw, "R5 direction");
            if (!rnw) chk(bus_wdata, d, "R5 write data");
            for (int i = 0; i < 50 && ctrl_rd[11]; i++) @(negedge clk);
            chk(ctrl_rd[11], 0, "R4 start cleared");
            chk(bus_req, 0, "R4 request dropped");
            chk(hs_count, hs0 + 1, "R4 one handshake");
            if (berr) exp_err = 1'b1;
            else if (rnw) exp_data = mem_word(a) & lane_mask(exp_be(sz, a[1:0]));
            chk(ctrl_rd[10], exp_err, berr ? "R7 error flag" : "R9 error sticky");
            chk(data_rd, exp_data, rnw ? (berr ? "R7 data kept" : "R6 read lanes") : "R5 data kept");
        end
        chk(ctrl_rd & ~32'h0000_0C00, ctrl_word(1'b1, 1'b0, rnw, sz), "R2 control fields");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(addr_rd, 0, "R1 address reset");
        chk(data_rd, 0, "R1 data reset");
        chk(ctrl_rd, 0, "R1 control reset");
        chk(bus_req, 0, "R1 no request");

        // R2 read-back and error bit not settable by write
        reg_write(2'd2, 32'hFFFF_F7FF);
        chk(ctrl_rd, 32'h0002_0380, "R2 layout, error not set by write");
        reg_write(2'd3, 32'h1234_5678);
        chk(addr_rd, 0, "R2 select 3 writes nothing");
        chk(data_rd, 0, "R2 select 3 writes nothing");

        // R3 start without enable
        reg_write(2'd0, 32'h0000_0100);
        reg_write(2'd2, ctrl_word(1'b0, 1'b1, 1'b1, 2'b10));
        chk(bus_req, 0, "R3 no request without enable");
        chk(ctrl_rd[11], 0, "R3 start not set");
        repeat (3) @(negedge clk);
        chk(hs_count, 0, "R3 no handshake");

        // directed lanes
        xfer(32'h0000_1003, 32'hAAAA_AAAA, 1'b1, 2'b00, 0, 1'b0);
        xfer(32'h0000_2002, 32'h0, 1'b1, 2'b01, 2, 1'b0);
        xfer(32'h0000_3000, 32'h0, 1'b1, 2'b10, 1, 1'b0);
        xfer(32'h0000_4001, 32'h7777_7777, 1'b0, 2'b00, 0, 1'b0);
        xfer(32'h0000_5000, 32'hBEEF_BEEF, 1'b0, 2'b01, 3, 1'b0);
        // R7 erroring read keeps data, error sticky afterwards (R9)
        xfer(32'h0000_6000, 32'h0, 1'b1, 2'b10, 1, 1'b1);
        xfer(32'h0000_7004, 32'h0, 1'b1, 2'b10, 0, 1'b0);
        // R9 clear
        reg_write(2'd2, 32'h0);
        exp_err = 1'b0;
        chk(ctrl_rd[10], 0, "R9 cleared by idle write");
        // R8 refused sizes
        xfer(32'h0000_8001, 32'h0, 1'b1, 2'b01, 0, 1'b0);
        xfer(32'h0000_8000, 32'h0, 1'b0, 2'b11, 0, 1'b0);
        reg_write(2'd2, 32'h0);
        exp_err = 1'b0;

        // R10 writes while busy are ignored
        resp_delay = 6;
        resp_err   = 1'b0;
        reg_write(2'd0, 32'h0000_9000);
        reg_write(2'd1, 32'h1111_2222);
        reg_write(2'd2, ctrl_word(1'b1, 1'b1, 1'b0, 2'b10));
        reg_write(2'd0, 32'hDEAD_0000);
        reg_write(2'd1, 32'h3333_4444);
        reg_write(2'd2, 32'h0);
        for (int i = 0; i < 50 && ctrl_rd[11]; i++) @(negedge clk);
        chk(addr_rd, 32'h0000_9000, "R10 address kept");
        chk(data_rd, 32'h1111_2222, "R10 data kept");
        chk(ctrl_rd, ctrl_word(1'b1, 1'b0, 1'b0, 2'b10), "R10 control kept");
        exp_data = 32'h1111_2222;

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            logic [1:0]  sz  = 2'($urandom_range(0, 7) == 0 ? 3 : $urandom_range(0, 2));
            logic [31:0] a   = $urandom;
            logic        rnw = 1'($urandom);
            logic [31:0] d   = $urandom;
            if (sz == 2'b00) d = {4{d[7:0]}};
            else if (sz == 2'b01) d = {2{d[15:0]}};
            if ($urandom_range(0, 5) == 0) begin
                reg_write(2'd2, 32'h0);
                exp_err = 1'b0;
                chk(ctrl_rd[10], 0, "R9 random clear");
            end
            xfer(a, d, rnw, sz, $urandom_range(0, 3), $urandom_range(0, 7) == 0);
        end
        report();
    end
endmodule